// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is a serial test port controller. Four test pins drive it: a test clock, a mode-select line, a serial data input and a serial data output. It holds the sixteen-state controller, a three-bit instruction register and three data registers that the instruction selects for scanning: a one-bit bypass stage, a 32-bit identification word and a boundary chain of parameterised length, 107 cells by default. The boundary chain connects to the rest of the chip through a parallel capture input and a parallel update output. A separate flag reports when the external-test instruction is active.

The pins here are test pins, not data streams, so there is no valid/ready handshake. Each rising test-clock edge samples the mode-select line and the serial input. The serial output changes only on falling edges. An active-low asynchronous reset forces the controller into its reset state, and so do five rising edges in a row with mode-select high. Either way the identification instruction is selected.

Top module: `scan_tap`

## Requirements
- R1: The controller moves between its sixteen states on each rising test-clock edge according to the standard mode-select transition graph. Capture happens in the capture states, shifting in the shift states, and register loading in the update states.
- R2: Five consecutive rising edges with mode-select high bring the controller to Test-Logic-Reset from any state. The asynchronous reset does the same at once.
- R3: In Test-Logic-Reset, and after reset, the instruction register holds the identification code 3'b001.
- R4: An instruction scan captures the fixed pattern 3'b001 and shifts it out least significant bit first. The new code takes effect in Update-IR. The codes are: 000 external test, 001 identification, 100 sample/preload, 111 bypass, and every other code selects bypass.
- R5: The identification register returns, least significant bit first, a 32-bit word. Its revision field sits in bits 31:29, the part code in bits 28:12, the vendor code in bits 11:1, and bit 0 is always 1.
- R6: Under bypass, the scan path is one stage long and captures 0.
- R7: Under sample/preload and external test, Capture-DR loads the parallel capture input into the boundary chain. That data leaves cell 0 first, while new serial data enters the highest cell in the same scan.
- R8: The parallel update output takes the boundary chain contents in Update-DR, and only when sample/preload or external test is selected. At all other times it holds its value. Reset clears it to zero.
- R9: The serial output changes only on falling test-clock edges. Its enable is high only in Shift-DR and Shift-IR. While the enable is low, the serial output is 0.
- R10: The external-test flag is high exactly while code 000 is the current instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in, sampled on rising tck |
| tdo | output | 1 | Serial data out, changes on falling tck |
| tdo_en | output | 1 | High while tdo carries scan data |
| bnd_pin_in | input | BSR_LEN | Parallel values captured into the boundary chain |
| bnd_upd_out | output | BSR_LEN | Boundary update register |
| extest_mode | output | 1 | External-test instruction is active |

## Verification
Two functions overlap in the same shift cycle under sample/preload. The captured parallel value leaves on tdo while preload data enters on tdi. The bench drives a pin pattern and a different serial pattern through a 140-bit scan. Each output bit is compared with the captured cell, and after bit 107 with the delayed serial input. The update register is then compared with the last 107 bits shifted in. The bench sweeps all eight instruction codes, and leaves the mode-select reset path from shift and pause states.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;
  localparam int IR_W = 3;

  localparam logic [IR_W-1:0] OP_EXTEST = 3'b000;
  localparam logic [IR_W-1:0] OP_IDCODE = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPLE = 3'b100;
  localparam logic [IR_W-1:0] OP_BYPASS = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPTURE_PAT = 3'b001;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {DRS_BYP, DRS_ID, DRS_BSR} dr_sel_e;

  function automatic dr_sel_e pick_dr(input logic [IR_W-1:0] op);
    case (op)
      OP_IDCODE:            return DRS_ID;
      OP_EXTEST, OP_SAMPLE: return DRS_BSR;
      default:              return DRS_BYP;
    endcase
  endfunction
endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
  import scan_tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state
);
  tap_state_e nxt;

  always_comb begin
    case (state)
      ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_IDLE;
      default:   nxt = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= ST_RESET;
    else         state <= nxt;
  end
endmodule

// File: rtl/scan_tap_ir.sv
module scan_tap_ir
  import scan_tap_pkg::*;
(
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tdi,
  input  tap_state_e      state,
  output logic [IR_W-1:0] ir_sh,
  output logic [IR_W-1:0] ir_q
);
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sh <= IR_CAPTURE_PAT;
      ir_q  <= OP_IDCODE;
    end else begin
      case (state)
        ST_RESET:  ir_q  <= OP_IDCODE;
        ST_CAP_IR: ir_sh <= IR_CAPTURE_PAT;
        ST_SH_IR:  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
        ST_UPD_IR: ir_q  <= ir_sh;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/scan_tap_dr.sv
module scan_tap_dr
  import scan_tap_pkg::*;
#(
  parameter int          BSR_LEN = 107,
  parameter logic [31:0] ID_WORD = 32'h0000_0001
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tdi,
  input  tap_state_e         state,
  input  dr_sel_e            sel,
  input  logic [BSR_LEN-1:0] bnd_pin_in,
  output logic [BSR_LEN-1:0] bnd_upd_out,
  output logic               dr_so
);
  logic               byp_q;
  logic [31:0]        id_sh;
  logic [BSR_LEN-1:0] bsr_sh;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      byp_q       <= 1'b0;
      id_sh       <= '0;
      bsr_sh      <= '0;
      bnd_upd_out <= '0;
    end else begin
      case (state)
        ST_CAP_DR: begin
          case (sel)
            DRS_ID:  id_sh  <= ID_WORD;
            DRS_BSR: bsr_sh <= bnd_pin_in;
            default: byp_q  <= 1'b0;
          endcase
        end
        ST_SH_DR: begin
          case (sel)
            DRS_ID:  id_sh  <= {tdi, id_sh[31:1]};
            DRS_BSR: bsr_sh <= {tdi, bsr_sh[BSR_LEN-1:1]};
            default: byp_q  <= tdi;
          endcase
        end
        ST_UPD_DR: if (sel == DRS_BSR) bnd_upd_out <= bsr_sh;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      DRS_ID:  dr_so = id_sh[0];
      DRS_BSR: dr_so = bsr_sh[0];
      default: dr_so = byp_q;
    endcase
  end
endmodule

// File: rtl/scan_tap.sv
module scan_tap
  import scan_tap_pkg::*;
#(
  parameter int           BSR_LEN = 107,
  parameter logic [2:0]   ID_REV  = 3'd0,
  parameter logic [16:0]  ID_PART = 17'h1A5A6,
  parameter logic [10:0]  ID_VEND = 11'h034
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tms,
  input  logic               tdi,
  output logic               tdo,
  output logic               tdo_en,
  input  logic [BSR_LEN-1:0] bnd_pin_in,
  output logic [BSR_LEN-1:0] bnd_upd_out,
  output logic               extest_mode
);
  localparam logic [31:0] ID_WORD = {ID_REV, ID_PART, ID_VEND, 1'b1};

  tap_state_e      state;
  logic [IR_W-1:0] ir_sh;
  logic [IR_W-1:0] ir_q;
  dr_sel_e         sel;
  logic            dr_so;

  scan_tap_fsm u_fsm (.tck(tck), .trst_n(trst_n), .tms(tms), .state(state));

  scan_tap_ir u_ir (.tck(tck), .trst_n(trst_n), .tdi(tdi), .state(state),
                    .ir_sh(ir_sh), .ir_q(ir_q));

  assign sel         = pick_dr(ir_q);
  assign extest_mode = (ir_q == OP_EXTEST);

  scan_tap_dr #(.BSR_LEN(BSR_LEN), .ID_WORD(ID_WORD)) u_dr (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .state(state), .sel(sel),
    .bnd_pin_in(bnd_pin_in), .bnd_upd_out(bnd_upd_out), .dr_so(dr_so));

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo_en <= (state == ST_SH_DR) || (state == ST_SH_IR);
      if (state == ST_SH_IR)      tdo <= ir_sh[0];
      else if (state == ST_SH_DR) tdo <= dr_so;
      else                        tdo <= 1'b0;
    end
  end
endmodule

// File: rtl/scan_tap_chk.sv
module scan_tap_chk
  import scan_tap_pkg::*;
#(
  parameter int BSR_LEN = 107
) (
  input logic               tck,
  input logic               trst_n,
  input logic               tms,
  input tap_state_e         state,
  input logic [IR_W-1:0]    ir_sh,
  input logic [IR_W-1:0]    ir_q,
  input logic               tdo,
  input logic               tdo_en,
  input logic [BSR_LEN-1:0] bnd_upd_out
);
  logic [2:0] ones_cnt;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)  ones_cnt <= '0;
    else if (tms) ones_cnt <= (ones_cnt == 3'd5) ? 3'd5 : ones_cnt + 3'd1;
    else          ones_cnt <= '0;
  end

  a_r2_five_ones: assert property (@(posedge tck) disable iff (!trst_n)
    (ones_cnt == 3'd5) |-> (state == ST_RESET));

  a_r3_reset_loads_id: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_RESET) |=> (ir_q == OP_IDCODE));

  a_r4_ir_capture: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_CAP_IR) |=> (ir_sh == IR_CAPTURE_PAT));

  a_r8_upd_hold: assert property (@(posedge tck) disable iff (!trst_n)
    (state != ST_UPD_DR) |=> $stable(bnd_upd_out));

  a_r9_en_in_shift: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_en |-> (state == ST_SH_DR || state == ST_SH_IR));

  a_r9_tdo_quiet: assert property (@(posedge tck) disable iff (!trst_n)
    !tdo_en |-> !tdo);
endmodule

bind scan_tap scan_tap_chk #(.BSR_LEN(BSR_LEN)) chk_i (
  .tck(tck), .trst_n(trst_n), .tms(tms), .state(state), .ir_sh(ir_sh),
  .ir_q(ir_q), .tdo(tdo), .tdo_en(tdo_en), .bnd_upd_out(bnd_upd_out));

// File: tb/scan_tap_tb_top.sv
module scan_tap_tb_top;
  localparam int          BL   = 107;
  localparam logic [2:0]  REV  = 3'd5;
  localparam logic [16:0] PART = 17'h0B3C5;
  localparam logic [10:0] VEND = 11'h2A1;
  localparam logic [31:0] IDW  = {REV, PART, VEND, 1'b1};
  localparam int          NSH  = 140;

  logic          tck = 1'b0;
  logic          trst_n = 1'b0;
  logic          tms = 1'b1;
  logic          tdi = 1'b0;
  logic          tdo, tdo_en, extest_mode;
  logic [BL-1:0] bnd_pin_in = '0;
  logic [BL-1:0] bnd_upd_out;

  int errors = 0;
  int checks = 0;

  logic [199:0] vin, vout, vexp;

  always #2 tck = ~tck;

  scan_tap #(.BSR_LEN(BL), .ID_REV(REV), .ID_PART(PART), .ID_VEND(VEND)) dut_i (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
    .bnd_pin_in(bnd_pin_in), .bnd_upd_out(bnd_upd_out), .extest_mode(extest_mode));

  task automatic chk(input string req, input logic [199:0] act, input logic [199:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck); @(negedge tck); #1;
  endtask

  // From Run-Test/Idle, scan n bits of vin, collect vout, return to idle.
  task automatic dr_scan(input int n);
    vout = '0;
    tick(1, 0); tick(0, 0); tick(0, 0);
    chk("R1 R9 enable in Shift-DR", 200'(tdo_en), 200'(1));
    vout[0] = tdo;
    for (int i = 0; i < n; i++) begin
      tick(i == n - 1, vin[i]);
      if (i < n - 1) vout[i+1] = tdo;
    end
    chk("R9 quiet in Exit1-DR", 200'({tdo_en, tdo}), 200'(0));
    tick(1, 0); tick(0, 0);
  endtask

  task automatic ir_scan(input logic [2:0] code, output logic [2:0] cap);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    cap[0] = tdo;
    for (int i = 0; i < 3; i++) begin
      tick(i == 2, code[i]);
      if (i < 2) cap[i+1] = tdo;
    end
    tick(1, 0); tick(0, 0);
  endtask

  task automatic id_check(input string req);
    for (int i = 0; i < 200; i++) vin[i] = (i % 3 == 1);
    dr_scan(40);
    vexp = '0;
    vexp[31:0] = IDW;
    for (int i = 32; i < 40; i++) vexp[i] = vin[i-32];
    chk(req, vout, vexp);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [2:0]    cap;
    logic [BL-1:0] upd_before;
    repeat (3) @(negedge tck);
    #1;
    chk("R9 reset tdo", 200'({tdo_en, tdo}), 200'(0));
    chk("R8 reset update reg", 200'(bnd_upd_out), 200'(0));
    chk("R10 reset flag", 200'(extest_mode), 200'(0));
    trst_n = 1'b1;
    tick(0, 0);

    id_check("R3 R5 ID after reset");

    // Sweep every instruction code.
    for (int code = 0; code < 8; code++) begin
      for (int i = 0; i < BL; i++) bnd_pin_in[i] = ((i * 7 + code) % 3 == 0);
      ir_scan(3'(code), cap);
      chk("R4 IR capture pattern", 200'(cap), 200'(3'b001));
      chk("R10 extest flag", 200'(extest_mode), 200'(code == 0));
      upd_before = bnd_upd_out;
      for (int i = 0; i < 200; i++) vin[i] = (((i * 5 + code * 3) % 7) < 3);
      dr_scan(NSH);
      vexp = '0;
      if (code == 1) begin
        vexp[31:0] = IDW;
        for (int i = 32; i < NSH; i++) vexp[i] = vin[i-32];
        chk("R5 ID path", vout, vexp);
      end else if (code == 0 || code == 4) begin
        for (int i = 0; i < BL; i++)   vexp[i] = bnd_pin_in[i];
        for (int i = BL; i < NSH; i++) vexp[i] = vin[i-BL];
        chk("R7 capture out, preload in", vout, vexp);
      end else begin
        for (int i = 1; i < NSH; i++) vexp[i] = vin[i-1];
        chk("R6 bypass path", vout, vexp);
      end
      if (code == 0 || code == 4) begin
        vexp = '0;
        for (int j = 0; j < BL; j++) vexp[j] = vin[j + NSH - BL];
        chk("R8 update loaded", 200'(bnd_upd_out), vexp);
      end else begin
        chk("R8 update held", 200'(bnd_upd_out), 200'(upd_before));
      end
    end

    // Five TMS-high edges from Shift-DR.
    ir_scan(3'b111, cap);
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int k = 0; k < 5; k++) tick(1, 0);
    tick(0, 0);
    id_check("R2 R3 five-ones from Shift-DR");

    // Five TMS-high edges from Pause-IR.
    ir_scan(3'b100, cap);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0); tick(1, 0); tick(0, 0);
    for (int k = 0; k < 5; k++) tick(1, 0);
    tick(0, 0);
    id_check("R2 R3 five-ones from Pause-IR");
    chk("R10 flag after reset", 200'(extest_mode), 200'(0));

    // Asynchronous reset in the middle of a scan.
    ir_scan(3'b000, cap);
    chk("R10 extest selected", 200'(extest_mode), 200'(1));
    tick(1, 0); tick(0, 0); tick(0, 0); tick(0, 1); tick(0, 0);
    trst_n = 1'b0;
    #1;
    chk("R2 async reset update reg", 200'(bnd_upd_out), 200'(0));
    chk("R9 async reset tdo", 200'({tdo_en, tdo}), 200'(0));
    chk("R10 async reset flag", 200'(extest_mode), 200'(0));
    @(negedge tck); @(negedge tck); #1;
    trst_n = 1'b1;
    tick(0, 0);
    id_check("R2 R3 ID after async reset");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule